// File: doc/BRIEF.md
# Branch Condition and Loop Evaluator

This block settles whether a conditional control transfer happens. It checks a 4-bit condition selector against the negative (N), zero (Z), overflow (V) and carry (C) flags. The selector covers the single-flag tests, the unsigned comparisons, the signed comparisons, and a constant true and a constant false. In branch mode a true condition sends the program counter to the branch target. The incoming program counter already points past the instruction, and the target is that counter plus a sign-extended displacement.

In loop mode the block runs the count-and-branch primitive. A true condition ends the loop at once: the counter is left alone and execution falls through. A false condition decrements only the low half-word of the counter register, and the upper half passes through unchanged. The block then branches back unless the new low half-word is all ones, that is minus one.

A request is taken on a rising clock edge while `req_valid` is high. The result is registered and appears one cycle later, flagged by `rsp_valid`. Between requests the outputs keep their last values.

Top module: `brloop_eval`

## Requirements
- R1: While `rst_n` is low at a rising edge, `rsp_valid`, `take`, `next_pc` and `ctr_out` all become zero.
- R2: `rsp_valid` is high exactly in the cycle after a request edge. After an edge without a request, `take`, `next_pc` and `ctr_out` keep their previous values whatever the other inputs do.
- R3: Single-flag and unsigned selector codes: 2 is C=0 and Z=0, 3 is C=1 or Z=1, 4 is C=0, 5 is C=1, 6 is Z=0, 7 is Z=1, 8 is V=0, 9 is V=1, 10 is N=0, 11 is N=1.
- R4: Signed selector codes: 12 is true when N equals V, 13 when N differs from V, 14 when Z=0 and N equals V, 15 when Z=1 or N differs from V.
- R5: Selector code 0 is always true and code 1 is always false, whatever the flags are.
- R6: When `take` is high, `next_pc` is `pc_in + disp` modulo 2^32. When `take` is low, `next_pc` equals `pc_in`.
- R7: In branch mode (`loop_mode`=0), `take` follows the condition and `ctr_out` equals `ctr_in` unchanged.
- R8: In loop mode with a false condition, `ctr_out[15:0]` is `ctr_in[15:0]` minus one modulo 2^16, and `ctr_out[31:16]` equals `ctr_in[31:16]`.
- R9: In loop mode with a false condition, `take` is high unless the decremented low half-word equals 16'hFFFF.
- R10: In loop mode with a true condition, `take` is low, `ctr_out` equals `ctr_in` and `next_pc` equals `pc_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Evaluate the inputs at this edge |
| loop_mode | input | 1 | 0 selects branch mode, 1 selects the counted loop |
| cond_sel | input | 4 | Condition selector code |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| ctr_in | input | 32 | Loop counter register value |
| disp | input | 32 | Sign-extended branch displacement |
| pc_in | input | 32 | Program counter already advanced past the instruction |
| rsp_valid | output | 1 | Result registered from the previous edge's request |
| take | output | 1 | Control transfer taken |
| next_pc | output | 32 | Program counter to continue from |
| ctr_out | output | 32 | Updated counter register value |

## Verification
Every result is due one rising edge after the request edge: `rsp_valid`, `take`, `next_pc` and `ctr_out` all pass through a single register stage and have no other latency. The bench changes inputs on falling edges and reads the outputs on the next falling edge, half a cycle after the register updates, so each check lands in the cycle where its result is due. Hold behaviour is checked one cycle later, after an idle edge with scrambled inputs. The counter corners are also driven: a low half-word of zero (the loop exits and wraps to all ones), a low half-word of one (the last taken pass), and nonzero upper bits.

// File: rtl/brloop_pkg.sv
// Package: shared types for the branch condition and loop evaluator.
// Assumes the selector encoding below is the one the decoder produces.
package brloop_pkg;

    // Condition selector codes; the values form the decode contract.
    typedef enum logic [3:0] {
        SEL_TRUE  = 4'd0,
        SEL_FALSE = 4'd1,
        SEL_UGT   = 4'd2,
        SEL_ULE   = 4'd3,
        SEL_NOC   = 4'd4,
        SEL_CY    = 4'd5,
        SEL_NZ    = 4'd6,
        SEL_ZR    = 4'd7,
        SEL_NOV   = 4'd8,
        SEL_OV    = 4'd9,
        SEL_POS   = 4'd10,
        SEL_NEG   = 4'd11,
        SEL_SGE   = 4'd12,
        SEL_SLT   = 4'd13,
        SEL_SGT   = 4'd14,
        SEL_SLE   = 4'd15
    } cond_sel_e;

    // Flag bundle as delivered by the status register.
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

endpackage

// File: rtl/brloop_cond.sv
// Module: brloop_cond
// Combinational condition evaluator: maps a selector code and the four
// flags to a single true/false. Assumes flags are stable for the cycle.
module brloop_cond
    import brloop_pkg::*;
(
    input  logic [3:0] sel,
    input  flags_t     flags,
    output logic       hit
);

    logic sign_ok;

    // Signed compare helper: N and V agree means "not less".
    always_comb sign_ok = (flags.n == flags.v);

    // Decode the selector into its flag equation.
    always_comb begin
        unique case (cond_sel_e'(sel))
            SEL_TRUE:  hit = 1'b1;
            SEL_FALSE: hit = 1'b0;
            SEL_UGT:   hit = !flags.c && !flags.z;
            SEL_ULE:   hit = flags.c || flags.z;
            SEL_NOC:   hit = !flags.c;
            SEL_CY:    hit = flags.c;
            SEL_NZ:    hit = !flags.z;
            SEL_ZR:    hit = flags.z;
            SEL_NOV:   hit = !flags.v;
            SEL_OV:    hit = flags.v;
            SEL_POS:   hit = !flags.n;
            SEL_NEG:   hit = flags.n;
            SEL_SGE:   hit = sign_ok;
            SEL_SLT:   hit = !sign_ok;
            SEL_SGT:   hit = sign_ok && !flags.z;
            SEL_SLE:   hit = !sign_ok || flags.z;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/brloop_count.sv
// Module: brloop_count
// Combinational loop counter step: decrements only the low CNT_W bits of
// the counter and reports when the pre-decrement value was zero, which is
// the case where the new low field becomes all ones and the loop exits.
// Assumes CNT_W <= CTR_W.
module brloop_count #(
    parameter int CTR_W = 32,
    parameter int CNT_W = 16
) (
    input  logic [CTR_W-1:0] ctr_in,
    input  logic             step,
    output logic [CTR_W-1:0] ctr_out,
    output logic             exhausted
);

    localparam int HI_W = CTR_W - CNT_W;

    logic [CNT_W-1:0] low_cur;
    logic [CNT_W-1:0] low_dec;

    // Split off the counted field and form its decrement.
    always_comb begin
        low_cur = ctr_in[CNT_W-1:0];
        low_dec = low_cur - {{(CNT_W-1){1'b0}}, 1'b1};
    end

    // Exit detect on the input side, in parallel with the subtractor.
    always_comb exhausted = (low_cur == '0);

    // Counted field: decremented only when a step is requested.
    always_comb ctr_out[CNT_W-1:0] = step ? low_dec : low_cur;

    // Bits above the counted field pass through untouched when present.
    generate
        if (HI_W > 0) begin : g_upper
            always_comb ctr_out[CTR_W-1:CNT_W] = ctr_in[CTR_W-1:CNT_W];
        end
    endgenerate

endmodule

// File: rtl/brloop_target.sv
// Module: brloop_target
// Next program counter select: adds the displacement to the advanced
// program counter when the transfer is taken, else falls through.
// Assumes disp is already sign-extended to ADDR_W bits.
module brloop_target #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [ADDR_W-1:0] disp,
    input  logic              taken,
    output logic [ADDR_W-1:0] pc_nxt
);

    logic [ADDR_W-1:0] dest;

    // Single shared adder, wraps modulo 2^ADDR_W.
    always_comb dest = pc_in + disp;

    // Choose target or fall-through.
    always_comb pc_nxt = taken ? dest : pc_in;

endmodule

// File: rtl/brloop_eval.sv
// Module: brloop_eval (top)
// Branch condition and counted-loop evaluator with one register stage.
// Branch mode: take = condition. Loop mode: a true condition falls through
// with the counter untouched; a false one decrements the low counter field
// and branches unless that field wraps to all ones.
// Assumes synchronous active-low reset and sign-extended displacement.
module brloop_eval
    import brloop_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CTR_W  = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              loop_mode,
    input  logic [3:0]        cond_sel,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    input  logic [CTR_W-1:0]  ctr_in,
    input  logic [ADDR_W-1:0] disp,
    input  logic [ADDR_W-1:0] pc_in,
    output logic              rsp_valid,
    output logic              take,
    output logic [ADDR_W-1:0] next_pc,
    output logic [CTR_W-1:0]  ctr_out
);

    flags_t             flags;
    logic               cond_hit;
    logic               do_step;
    logic               cnt_done;
    logic               take_d;
    logic [CTR_W-1:0]   ctr_d;
    logic [ADDR_W-1:0]  pc_d;

    // Bundle the flag pins.
    always_comb flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};

    brloop_cond u_cond (
        .sel   (cond_sel),
        .flags (flags),
        .hit   (cond_hit)
    );

    // Counter steps only in loop mode with a false condition.
    always_comb do_step = loop_mode && !cond_hit;

    brloop_count #(
        .CTR_W (CTR_W),
        .CNT_W (CNT_W)
    ) u_count (
        .ctr_in    (ctr_in),
        .step      (do_step),
        .ctr_out   (ctr_d),
        .exhausted (cnt_done)
    );

    // Taken decision for the two modes.
    always_comb take_d = loop_mode ? (do_step && !cnt_done) : cond_hit;

    brloop_target #(
        .ADDR_W (ADDR_W)
    ) u_target (
        .pc_in  (pc_in),
        .disp   (disp),
        .taken  (take_d),
        .pc_nxt (pc_d)
    );

    // Response valid strobe, one cycle after each request.
    always_ff @(posedge clk) begin
        if (!rst_n) rsp_valid <= 1'b0;
        else        rsp_valid <= req_valid;
    end

    // Result registers, loaded on a request and held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take    <= 1'b0;
            next_pc <= '0;
            ctr_out <= '0;
        end else if (req_valid) begin
            take    <= take_d;
            next_pc <= pc_d;
            ctr_out <= ctr_d;
        end
    end

endmodule

// File: rtl/brloop_eval_chk.sv
// Module: brloop_eval_chk
// Port-level protocol and function checks for brloop_eval, bound below.
module brloop_eval_chk #(
    parameter int ADDR_W = 32,
    parameter int CTR_W  = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              loop_mode,
    input logic [3:0]        cond_sel,
    input logic              flag_n,
    input logic              flag_z,
    input logic              flag_v,
    input logic              flag_c,
    input logic [CTR_W-1:0]  ctr_in,
    input logic [ADDR_W-1:0] disp,
    input logic [ADDR_W-1:0] pc_in,
    input logic              rsp_valid,
    input logic              take,
    input logic [ADDR_W-1:0] next_pc,
    input logic [CTR_W-1:0]  ctr_out
);

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid && $stable(next_pc) && $stable(ctr_out) && $stable(take));

    assert_zero_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !loop_mode && cond_sel == 4'd7 && flag_z |=> take);

    assert_signed_less_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !loop_mode && cond_sel == 4'd13 && (flag_n != flag_v) |=> take);

    assert_const_false_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !loop_mode && cond_sel == 4'd1 |=> !take);

    assert_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (take ? (next_pc == $past(pc_in) + $past(disp)) : (next_pc == $past(pc_in))));

    assert_branch_ctr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !loop_mode |=> ctr_out == $past(ctr_in));

    assert_loop_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && loop_mode |=> ctr_out[CTR_W-1:CNT_W] == $past(ctr_in[CTR_W-1:CNT_W]));

    assert_loop_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && loop_mode && cond_sel == 4'd1 |=> (take == (ctr_out[CNT_W-1:0] != ALL_ONES)));

    assert_loop_true_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && loop_mode && cond_sel == 4'd0 |=> !take && ctr_out == $past(ctr_in));

endmodule

bind brloop_eval brloop_eval_chk #(
    .ADDR_W (ADDR_W),
    .CTR_W  (CTR_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .loop_mode (loop_mode),
    .cond_sel  (cond_sel),
    .flag_n    (flag_n),
    .flag_z    (flag_z),
    .flag_v    (flag_v),
    .flag_c    (flag_c),
    .ctr_in    (ctr_in),
    .disp      (disp),
    .pc_in     (pc_in),
    .rsp_valid (rsp_valid),
    .take      (take),
    .next_pc   (next_pc),
    .ctr_out   (ctr_out)
);

// File: tb/tb_brloop_eval.sv
module tb_brloop_eval;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        loop_mode;
    logic [3:0]  cond_sel;
    logic        flag_n, flag_z, flag_v, flag_c;
    logic [31:0] ctr_in, disp, pc_in;
    logic        rsp_valid, take;
    logic [31:0] next_pc, ctr_out;

    int vectors = 0;
    int errs    = 0;

    always #10 clk = ~clk;

    brloop_eval dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .loop_mode(loop_mode),
        .cond_sel(cond_sel), .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v),
        .flag_c(flag_c), .ctr_in(ctr_in), .disp(disp), .pc_in(pc_in),
        .rsp_valid(rsp_valid), .take(take), .next_pc(next_pc), .ctr_out(ctr_out)
    );

    // Reference condition table written from R3, R4, R5.
    function automatic bit ref_cond(input logic [3:0] s, input bit n, z, v, c);
        case (s)
            4'd0:  return 1'b1;
            4'd1:  return 1'b0;
            4'd2:  return (c == 0) && (z == 0);
            4'd3:  return (c == 1) || (z == 1);
            4'd4:  return c == 0;
            4'd5:  return c == 1;
            4'd6:  return z == 0;
            4'd7:  return z == 1;
            4'd8:  return v == 0;
            4'd9:  return v == 1;
            4'd10: return n == 0;
            4'd11: return n == 1;
            4'd12: return n == v;
            4'd13: return n != v;
            4'd14: return (z == 0) && (n == v);
            default: return (z == 1) || (n != v);
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request, wait one edge, compare against the model.
    task automatic apply(input bit lm, input logic [3:0] s, input bit n, z, v, c,
                         input logic [31:0] ctr, input logic [31:0] d, input logic [31:0] pc);
        bit          cnd, e_take;
        logic [31:0] e_ctr, e_pc;
        logic [15:0] lo;
        string       ttag;
        req_valid = 1'b1; loop_mode = lm; cond_sel = s;
        flag_n = n; flag_z = z; flag_v = v; flag_c = c;
        ctr_in = ctr; disp = d; pc_in = pc;
        cnd = ref_cond(s, n, z, v, c);
        if (!lm) begin
            e_take = cnd; e_ctr = ctr;
            ttag = (s >= 4'd12) ? "R4 take" : (s <= 4'd1) ? "R5 take" : "R3 take";
        end else if (cnd) begin
            e_take = 1'b0; e_ctr = ctr; ttag = "R10 take";
        end else begin
            lo = ctr[15:0] - 16'd1;
            e_ctr = {ctr[31:16], lo};
            e_take = (lo != 16'hFFFF); ttag = "R9 take";
        end
        e_pc = e_take ? pc + d : pc;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        check(ttag, {31'd0, take}, {31'd0, e_take});
        check(lm ? (cnd ? "R10 ctr_out" : "R8 ctr_out") : "R7 ctr_out", ctr_out, e_ctr);
        check(lm && cnd ? "R10 next_pc" : "R6 next_pc", next_pc, e_pc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

    initial begin
        logic [31:0] h_pc, h_ctr;
        logic        h_take;
        void'($urandom(32'h1BADC0DE));
        rst_n = 1'b0; req_valid = 1'b0; loop_mode = 1'b0; cond_sel = 4'd0;
        {flag_n, flag_z, flag_v, flag_c} = 4'b0;
        ctr_in = '0; disp = '0; pc_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R1 take", {31'd0, take}, 32'd0);
        check("R1 next_pc", next_pc, 32'd0);
        check("R1 ctr_out", ctr_out, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed: every code in branch mode across all flag patterns.
        for (int s = 0; s < 16; s++) begin
            for (int f = 0; f < 16; f++) begin
                apply(1'b0, s[3:0], f[3], f[2], f[1], f[0], 32'hA5A5_0003, 32'h0000_0010, 32'h0000_1000);
            end
        end
        // R6: wrap and negative displacement
        apply(1'b0, 4'd0, 0, 0, 0, 0, 32'h1, 32'h0000_0008, 32'hFFFF_FFFC);
        apply(1'b0, 4'd0, 0, 0, 0, 0, 32'h1, 32'hFFFF_FFF0, 32'h0000_0100);
        // R9: low field zero exits and wraps, upper bits kept (R8)
        apply(1'b1, 4'd1, 0, 0, 0, 0, 32'hDEAD_0000, 32'hFFFF_FFF8, 32'h0000_2000);
        // R9: low field one gives last taken pass
        apply(1'b1, 4'd1, 0, 0, 0, 0, 32'h1234_0001, 32'hFFFF_FFF8, 32'h0000_2000);
        apply(1'b1, 4'd7, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFE0, 32'h0000_3000);
        // R10: true condition falls through
        apply(1'b1, 4'd0, 0, 0, 0, 0, 32'h0000_0000, 32'h0000_0040, 32'h0000_4000);
        apply(1'b1, 4'd7, 0, 1, 0, 0, 32'h0055_0005, 32'h0000_0040, 32'h0000_4000);

        // R2: idle edge with scrambled inputs leaves outputs held.
        h_take = take; h_pc = next_pc; h_ctr = ctr_out;
        loop_mode = 1'b0; cond_sel = 4'd0; ctr_in = 32'h7777_7777;
        pc_in = 32'h8888_0000; disp = 32'h44;
        @(negedge clk);
        check("R2 idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check("R2 idle take", {31'd0, take}, {31'd0, h_take});
        check("R2 idle next_pc", next_pc, h_pc);
        check("R2 idle ctr_out", ctr_out, h_ctr);

        // Constrained random mix, with counters biased toward the exit edge.
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r_ctr;
            logic [3:0]  r_f;
            r_ctr = $urandom;
            if ($urandom_range(0, 3) == 0) r_ctr[15:0] = 16'($urandom_range(0, 2));
            r_f = 4'($urandom);
            apply(1'($urandom), 4'($urandom), r_f[3], r_f[2], r_f[1], r_f[0],
                  r_ctr, $urandom, $urandom);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
        $finish;
    end

endmodule